// File: doc/BRIEF.md
# Codec Command Slot Controller

This block lets software reach the registers of an external audio codec through a small set of 20-bit slot registers. Software first stores a data word in the transmit data slot. It then writes a command word into the transmit command slot. The command write starts one transaction on a codec-side request port. Bit 19 of the command word selects a codec register read or a codec register write. The 7-bit codec register address and the 16-bit write data sit at fixed bit positions inside the slot words.

For a codec write, the transaction ends when the codec accepts the request. For a codec read, the block waits for a single-cycle response strobe. It then stores two values in the receive slots: the command word with its direction bit cleared, and the returned value shifted into the upper 16 bits of the data slot. A flags word records several conditions: which transmit slots are still empty since reset, whether a read is outstanding, and whether each receive slot holds data not yet read. Software polls the flags word and reads the result back through a one-cycle-latency read port.

Top module: `codec_slot_ctrl`

## Requirements
- R1: After reset, the flags word reads 0x07 and all four slot registers read zero. The flag bit positions are: bit0 command-slot empty, bit1 data-slot empty, bit2 both-slots empty, bit3 command receive busy, bit4 data receive busy, bit5 command receive valid, bit6 data receive valid.
- R2: A write to select 1 (transmit data) stores the 20-bit word and clears the data-empty flag. Bit2 is set only while both transmit slots are empty. A data write starts no request.
- R3: A write to select 0 (transmit command) while no transaction is pending clears the command-empty flag. On the next cycle it raises req_valid, with req_addr taken from command bits 18:12 and req_read taken from bit 19 (1 means read).
- R4: req_data equals bits 19:4 of the data slot at the moment of the command write. The address, data and direction on the request port hold steady while req_valid is high and req_ready is low.
- R5: A read request sets both receive-busy flags. A write request changes no receive flag and no receive slot.
- R6: While a read is outstanding, rsp_valid stores the command word with bit 19 cleared into the receive command slot (select 2), and rsp_data shifted left by 4 into the receive data slot (select 3). The same strobe clears both busy flags and sets both valid flags.
- R7: Reading select 2 or select 3 clears that slot's valid flag. If a response lands in the same cycle, the flag stays set and the read returns the value held before the response.
- R8: A command write arriving while a request waits for acceptance, or while a read is outstanding, has no effect.
- R9: rsp_valid has no effect when no read is outstanding.
- R10: rd_data presents the register chosen by rd_sel one cycle after rd_en. Select 4 is the flags word, zero-extended. Other selects read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 20 | Write value |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register select for a read |
| rd_data | output | 20 | Read value, one cycle after rd_en |
| req_valid | output | 1 | Codec request present |
| req_ready | input | 1 | Codec accepts the request |
| req_read | output | 1 | 1 = codec register read, 0 = write |
| req_addr | output | 7 | Codec register address |
| req_data | output | 16 | Codec write data |
| rsp_valid | input | 1 | Single-cycle read response strobe |
| rsp_data | input | 16 | Returned codec register value |

## Verification
Two events can meet on the same clock edge: software reading a receive slot, which clears that slot's valid flag, and the codec response, which fills the slot and sets the flag. The bench raises rd_en for the receive data slot in the very cycle that it drives rsp_valid. It then expects the read to return the previous contents, the flags word to show the valid bit still set, and a following read to return the new value. A second overlap is a command write during an outstanding read. This is judged by the absence of a new request and by the receive command slot still mirroring the original command.

// File: rtl/codec_slot_pkg.sv
// Shared widths, register selects, flag bit positions and controller states
// for the codec command slot controller. Assumes a 20-bit slot word.
package codec_slot_pkg;

    localparam int SLOT_W  = 20;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 3;
    localparam int FLAG_W  = 7;

    localparam int DIR_BIT  = SLOT_W - 1;                 // read/write direction
    localparam int ADDR_LSB = DIR_BIT - ADDR_W;           // 12
    localparam int DATA_LSB = SLOT_W - DATA_W;            // 4

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD_TX = 3'd0,
        SEL_DAT_TX = 3'd1,
        SEL_CMD_RX = 3'd2,
        SEL_DAT_RX = 3'd3,
        SEL_FLAGS  = 3'd4
    } slot_sel_e;

    localparam int FL_CMD_EMPTY = 0;
    localparam int FL_DAT_EMPTY = 1;
    localparam int FL_ALL_EMPTY = 2;
    localparam int FL_CMD_BUSY  = 3;
    localparam int FL_DAT_BUSY  = 4;
    localparam int FL_CMD_VALID = 5;
    localparam int FL_DAT_VALID = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } xact_state_e;

endpackage

// File: rtl/slot_tx_bank.sv
// Transmit slot registers. Holds the command and data slot words written by
// software, together with their empty flags. A command write is taken only
// when the transaction controller reports idle; it then produces a launch
// pulse. Assumes one register write per cycle.
module slot_tx_bank
    import codec_slot_pkg::*;
#(
    parameter int W = SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             ctrl_idle,
    output logic             launch,
    output logic [W-1:0]     cmd_q,
    output logic [W-1:0]     dat_q,
    output logic             cmd_empty,
    output logic             dat_empty
);

    logic cmd_wr;
    logic dat_wr;

    // Decode accepted writes; a command write counts only when idle.
    always_comb begin
        dat_wr = wr_en && (wr_sel == SEL_DAT_TX);
        cmd_wr = wr_en && (wr_sel == SEL_CMD_TX) && ctrl_idle;
        launch = cmd_wr;
    end

    // Command slot word and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            cmd_empty <= 1'b1;
        end else if (cmd_wr) begin
            cmd_q     <= wr_data;
            cmd_empty <= 1'b0;
        end
    end

    // Data slot word and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q     <= '0;
            dat_empty <= 1'b1;
        end else if (dat_wr) begin
            dat_q     <= wr_data;
            dat_empty <= 1'b0;
        end
    end

endmodule

// File: rtl/slot_xact_ctrl.sv
// Transaction controller. On launch it snapshots the direction, address and
// write data, presents them on the codec request port until accepted, and for
// reads waits for the response strobe. Assumes the codec never answers a read
// in the same cycle in which it accepts the request.
module slot_xact_ctrl
    import codec_slot_pkg::*;
#(
    parameter int W  = SLOT_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [W-1:0]  cmd_word,
    input  logic [W-1:0]  dat_word,
    input  logic          req_ready,
    input  logic          rsp_valid,
    output logic          ctrl_idle,
    output logic          rd_launch,
    output logic          rd_done,
    output logic          req_valid,
    output logic          req_read,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data
);

    localparam int A_LSB = W - 1 - AW;
    localparam int D_LSB = W - DW;

    xact_state_e state_q;
    xact_state_e state_d;

    // Status pulses derived from state and inputs.
    always_comb begin
        ctrl_idle = (state_q == ST_IDLE);
        rd_launch = launch && cmd_word[W-1];
        rd_done   = (state_q == ST_WAIT) && rsp_valid;
        req_valid = (state_q == ST_REQ);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_REQ;
            ST_REQ:  if (req_ready) state_d = req_read ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot of the request fields taken at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_read <= 1'b0;
            req_addr <= '0;
            req_data <= '0;
        end else if (launch) begin
            req_read <= cmd_word[W-1];
            req_addr <= cmd_word[A_LSB +: AW];
            req_data <= dat_word[D_LSB +: DW];
        end
    end

endmodule

// File: rtl/slot_rx_bank.sv
// Receive slot registers with busy and valid flags. A read launch sets both
// busy flags; read completion stores the echoed command and the returned
// value and marks both slots valid. A software read of a slot clears its
// valid flag unless a completion lands in the same cycle.
module slot_rx_bank
    import codec_slot_pkg::*;
#(
    parameter int W  = SLOT_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_launch,
    input  logic          rd_done,
    input  logic [W-1:0]  cmd_word,
    input  logic [DW-1:0] rsp_data,
    input  logic          clr_cmd_valid,
    input  logic          clr_dat_valid,
    output logic [W-1:0]  rx_cmd,
    output logic [W-1:0]  rx_dat,
    output logic [1:0]    busy,
    output logic [1:0]    valid
);

    localparam int PAD = W - DW;

    logic [W-1:0] echo_cmd;
    logic [W-1:0] echo_dat;
    logic [1:0]   clr_vec;

    // Form the stored words and the per-slot clear requests.
    always_comb begin
        echo_cmd         = cmd_word;
        echo_cmd[W-1]    = 1'b0;
        echo_dat         = {rsp_data, {PAD{1'b0}}};
        clr_vec          = {clr_dat_valid, clr_cmd_valid};
    end

    // Receive slot contents, written only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cmd <= '0;
            rx_dat <= '0;
        end else if (rd_done) begin
            rx_cmd <= echo_cmd;
            rx_dat <= echo_dat;
        end
    end

    // Per-slot busy and valid flags; completion wins over a read clear.
    for (genvar i = 0; i < 2; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[i]  <= 1'b0;
                valid[i] <= 1'b0;
            end else begin
                if (rd_done)        busy[i] <= 1'b0;
                else if (rd_launch) busy[i] <= 1'b1;
                if (rd_done)         valid[i] <= 1'b1;
                else if (clr_vec[i]) valid[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/codec_slot_ctrl.sv
// Top of the codec command slot controller: register write and read-back
// ports for the slot registers and flags word, and the codec request and
// response ports. Read data is registered, one cycle after rd_en.
module codec_slot_ctrl
    import codec_slot_pkg::*;
#(
    parameter int W  = SLOT_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     rd_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_read,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_data,
    input  logic             rsp_valid,
    input  logic [DW-1:0]    rsp_data
);

    logic          ctrl_idle;
    logic          launch;
    logic          rd_launch;
    logic          rd_done;
    logic [W-1:0]  cmd_q;
    logic [W-1:0]  dat_q;
    logic          cmd_empty;
    logic          dat_empty;
    logic [W-1:0]  rx_cmd;
    logic [W-1:0]  rx_dat;
    logic [1:0]    rx_busy;
    logic [1:0]    rx_valid;
    logic [FLAG_W-1:0] flags;
    logic          clr_cmd_valid;
    logic          clr_dat_valid;

    slot_tx_bank #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl_idle (ctrl_idle),
        .launch    (launch),
        .cmd_q     (cmd_q),
        .dat_q     (dat_q),
        .cmd_empty (cmd_empty),
        .dat_empty (dat_empty)
    );

    slot_xact_ctrl #(.W(W), .AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd_word  (wr_data),
        .dat_word  (dat_q),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .ctrl_idle (ctrl_idle),
        .rd_launch (rd_launch),
        .rd_done   (rd_done),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_addr  (req_addr),
        .req_data  (req_data)
    );

    slot_rx_bank #(.W(W), .DW(DW)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_launch     (rd_launch),
        .rd_done       (rd_done),
        .cmd_word      (cmd_q),
        .rsp_data      (rsp_data),
        .clr_cmd_valid (clr_cmd_valid),
        .clr_dat_valid (clr_dat_valid),
        .rx_cmd        (rx_cmd),
        .rx_dat        (rx_dat),
        .busy          (rx_busy),
        .valid         (rx_valid)
    );

    // Assemble the flags word and decode read-side clears.
    always_comb begin
        flags                = '0;
        flags[FL_CMD_EMPTY]  = cmd_empty;
        flags[FL_DAT_EMPTY]  = dat_empty;
        flags[FL_ALL_EMPTY]  = cmd_empty && dat_empty;
        flags[FL_CMD_BUSY]   = rx_busy[0];
        flags[FL_DAT_BUSY]   = rx_busy[1];
        flags[FL_CMD_VALID]  = rx_valid[0];
        flags[FL_DAT_VALID]  = rx_valid[1];
        clr_cmd_valid        = rd_en && (rd_sel == SEL_CMD_RX);
        clr_dat_valid        = rd_en && (rd_sel == SEL_DAT_RX);
    end

    // Registered read-back multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (rd_sel)
                SEL_CMD_TX: rd_data <= cmd_q;
                SEL_DAT_TX: rd_data <= dat_q;
                SEL_CMD_RX: rd_data <= rx_cmd;
                SEL_DAT_RX: rd_data <= rx_dat;
                SEL_FLAGS:  rd_data <= W'(flags);
                default:    rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/codec_slot_checker.sv
// Protocol and flag checks for the codec command slot controller, attached
// to every instance of the top module by the bind statement below.
module codec_slot_checker
    import codec_slot_pkg::*;
#(
    parameter int W  = SLOT_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_read,
    input logic [AW-1:0]    req_addr,
    input logic [DW-1:0]    req_data,
    input logic             rsp_valid,
    input logic [FLAG_W-1:0] flags,
    input logic [W-1:0]     cmd_q,
    input logic [W-1:0]     rx_cmd,
    input logic [W-1:0]     rx_dat
);

    logic pending;
    always_comb pending = req_valid || flags[FL_CMD_BUSY];

    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == 7'h07));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_read)));

    assert_write_no_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_read) |=>
            ($stable(rx_cmd) && $stable(rx_dat) && !flags[FL_CMD_BUSY] && !flags[FL_DAT_BUSY]));

    assert_done_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && flags[FL_CMD_BUSY] && !req_valid) |=>
            (!flags[FL_CMD_BUSY] && !flags[FL_DAT_BUSY] &&
             flags[FL_CMD_VALID] && flags[FL_DAT_VALID]));

    assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_en && (wr_sel == SEL_CMD_TX)) |=> $stable(cmd_q));

    assert_stray_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !flags[FL_CMD_BUSY]) |=> ($stable(rx_cmd) && $stable(rx_dat)));

endmodule

bind codec_slot_ctrl codec_slot_checker #(.W(W), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_read  (req_read),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .flags     (flags),
    .cmd_q     (cmd_q),
    .rx_cmd    (rx_cmd),
    .rx_dat    (rx_dat)
);

// File: tb/tb_codec_slot_ctrl.sv
module tb_codec_slot_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [19:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [19:0] rd_data;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic        req_read;
    logic [6:0]  req_addr;
    logic [15:0] req_data;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;

    int checks = 0;
    int errors = 0;
    logic due = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    codec_slot_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares read-back data one cycle after rd_en.
    always @(posedge clk) due <= rd_en;
    always @(negedge clk) begin
        if (due) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected read data 0x%0h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), {12'd0, rd_data}, {12'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [19:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [19:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = sel;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic respond(input logic [15:0] val);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = val;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(3'd4, 20'h00007, "R1 flags after reset");
        rd(3'd2, 20'h00000, "R1 rx cmd after reset");
        rd(3'd3, 20'h00000, "R1 rx data after reset");

        // R2: data slot write
        wr(3'd1, 20'hABCD0);
        check("R2 no request on data write", {31'd0, req_valid}, 32'd0);
        rd(3'd4, 20'h00001, "R2 flags after data write");

        // R3/R4: codec write request, ready held low
        wr(3'd0, 20'h2A000);
        check("R3 req_valid after cmd write", {31'd0, req_valid}, 32'd1);
        check("R3 req_addr", {25'd0, req_addr}, 32'h2A);
        check("R3 req_read", {31'd0, req_read}, 32'd0);
        check("R4 req_data", {16'd0, req_data}, 32'hABCD);
        wr(3'd1, 20'h55550);
        check("R4 req_data held while waiting", {16'd0, req_data}, 32'hABCD);
        rd(3'd4, 20'h00000, "R3 flags after cmd write");
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        check("R3 req_valid dropped after accept", {31'd0, req_valid}, 32'd0);
        rd(3'd4, 20'h00000, "R5 write leaves rx flags");
        rd(3'd2, 20'h00000, "R5 write leaves rx cmd");

        // R5/R6: codec read with ready already high
        wr(3'd1, 20'hABCD0);
        req_ready = 1'b1;
        wr(3'd0, 20'h95005);
        check("R3 read req_addr", {25'd0, req_addr}, 32'h15);
        check("R3 read req_read", {31'd0, req_read}, 32'd1);
        @(negedge clk); req_ready = 1'b0;
        rd(3'd4, 20'h00018, "R5 busy flags during read");
        // R8: command write while read outstanding is ignored
        wr(3'd0, 20'h00000);
        check("R8 no request while read outstanding", {31'd0, req_valid}, 32'd0);
        rd(3'd0, 20'h95005, "R8 cmd slot unchanged");
        respond(16'h1234);
        rd(3'd4, 20'h00060, "R6 flags after completion");
        rd(3'd2, 20'h15005, "R6 rx cmd echo");
        rd(3'd4, 20'h00040, "R7 cmd valid cleared by read");
        rd(3'd3, 20'h12340, "R6 rx data shifted");
        rd(3'd4, 20'h00000, "R7 both valid cleared");

        // R7: response and rx-data read on the same edge
        req_ready = 1'b1;
        wr(3'd0, 20'h9A000);
        @(negedge clk); req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_data = 16'hBEEF;
        rd_en = 1'b1; rd_sel = 3'd3;
        exp_q.push_back(20'h12340); tag_q.push_back("R7 same-cycle read returns old data");
        @(negedge clk);
        rsp_valid = 1'b0; rd_en = 1'b0;
        rd(3'd4, 20'h00060, "R7 set wins over read clear");
        rd(3'd3, 20'hBEEF0, "R7 new data after overlap");
        rd(3'd2, 20'h1A000, "R6 second echo");

        // R9: stray response while idle
        respond(16'hFFFF);
        rd(3'd3, 20'hBEEF0, "R9 rx data unchanged");
        rd(3'd2, 20'h1A000, "R9 rx cmd unchanged");
        rd(3'd4, 20'h00000, "R9 flags unchanged");

        // R10: transmit read-back and unused select
        rd(3'd0, 20'h9A000, "R10 cmd slot readback");
        rd(3'd1, 20'hABCD0, "R10 data slot readback");
        rd(3'd7, 20'h00000, "R10 unused select");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: actual %0d pending reads expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule